// File: doc/BRIEF.md
# ASM Counter Controller with Completion Flags

This block is a small controller and datapath pair taken from an algorithmic state machine chart. A two-flip-flop state register feeds a 2-to-4 decoder. The decoder gives three one-hot state lines: idle, run and done.

In idle, the block waits for the start line. A start clears the 4-bit count and the done flag. While running, the count steps up by one on every clock. On the same edge, the tracking flag copies count bit 1 as it was before that edge. When the pre-edge count has bits 1 and 2 both set, the run ends. The done state then raises the done flag for one cycle and returns to idle.

Every decision uses register values from before the clock edge. The operations of a state and its decision paths all take effect on that single edge.

Top module: `asm_count_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle (`t0_o`=1), and `cnt_o`, `e_o` and `f_o` all become 0.
- R2: In idle with `start`=0, the block stays in idle, and `cnt_o`, `e_o` and `f_o` keep their values.
- R3: In idle with `start`=1, the next edge clears `cnt_o` to 0 and `f_o` to 0 and moves to run (`t1_o`=1).
- R4: In run, every edge increments `cnt_o` by one modulo 16, whatever the value of `start`.
- R5: In run, every edge loads `e_o` with the pre-edge value of `cnt_o[1]`.
- R6: In run, the next state is done (`t2_o`=1) when the pre-edge `cnt_o[1]` and `cnt_o[2]` are both 1. Otherwise it stays in run. From a start, the count therefore runs 0 through 6 and enters done holding 7.
- R7: In done, the next edge sets `f_o` to 1 and returns to idle, and `cnt_o` holds.
- R8: Exactly one of `t0_o`, `t1_o` and `t2_o` is 1 in every cycle. The state codes are idle 00, run 01 and done 11; code 10 leads back to idle.
- R9: `e_o` holds its value outside run, and `f_o` holds its value in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled in idle only |
| cnt_o | output | 4 | Count register |
| e_o | output | 1 | Tracking flag, loaded from count bit 1 during run |
| f_o | output | 1 | Done flag |
| t0_o | output | 1 | Idle state line |
| t1_o | output | 1 | Run state line |
| t2_o | output | 1 | Done state line |

## Verification
A single start pulse followed by a long quiet period walks through one whole run. It separates the pre-edge sampling of the exit test and of the tracking flag from post-edge sampling, because either mistake moves the exit point or shifts the E pattern by one count.

Holding start high across several runs shows that start is taken only in idle. It also shows that a restart clears the done flag right after it was set.

Random start pulses, with occasional resets that land mid-run, give idle gaps of many lengths and reset from each state. Each cycle is compared against a reference model of the chart.

// File: rtl/asm_count_pkg.sv
package asm_count_pkg;
  localparam int STW = 2;
  typedef enum logic [STW-1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_BAD  = 2'b10,
    ST_DONE = 2'b11
  } st_code_t;
endpackage

// File: rtl/asm_state_reg.sv
module asm_state_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_idle,
  input  logic       in_run,
  input  logic       start,
  input  logic       hit,
  output logic [1:0] g
);
  logic d_hi, d_lo;

  // next-state D inputs: code 10 decodes to no state, so both are 0 there
  assign d_hi = in_run & hit;
  assign d_lo = (in_idle & start) | in_run;

  always_ff @(posedge clk) begin
    if (rst) g <= asm_count_pkg::ST_IDLE;
    else     g <= {d_hi, d_lo};
  end
endmodule

// File: rtl/asm_state_dec.sv
module asm_state_dec #(
  parameter int SEL_W = 2,
  localparam int OUTS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [OUTS-1:0]  dec
);
  for (genvar i = 0; i < OUTS; i++) begin : g_line
    assign dec[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/asm_datapath.sv
module asm_datapath #(
  parameter int CNT_W  = 4,
  parameter int TAP_LO = 1,
  parameter int TAP_HI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_idle,
  input  logic             in_run,
  input  logic             in_done,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             e_flag,
  output logic             f_flag,
  output logic             hit
);
  assign hit = cnt[TAP_LO] & cnt[TAP_HI];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      e_flag <= 1'b0;
      f_flag <= 1'b0;
    end else begin
      if (in_idle && start) begin
        cnt    <= '0;
        f_flag <= 1'b0;
      end
      if (in_run) begin
        cnt    <= cnt + 1'b1;
        e_flag <= cnt[TAP_LO];
      end
      if (in_done) f_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/asm_count_ctl.sv
module asm_count_ctl #(
  parameter int CNT_W  = 4,
  parameter int TAP_LO = 1,
  parameter int TAP_HI = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] cnt_o,
  output logic             e_o,
  output logic             f_o,
  output logic             t0_o,
  output logic             t1_o,
  output logic             t2_o
);
  logic [1:0] g;
  logic [3:0] dec;
  logic       hit;
  logic       dec_unused;

  asm_state_reg u_sreg (
    .clk(clk), .rst(rst), .in_idle(dec[0]), .in_run(dec[1]),
    .start(start), .hit(hit), .g(g)
  );

  asm_state_dec #(.SEL_W(2)) u_dec (.sel(g), .dec(dec));

  asm_datapath #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_dp (
    .clk(clk), .rst(rst), .in_idle(dec[0]), .in_run(dec[1]),
    .in_done(dec[3]), .start(start), .cnt(cnt_o), .e_flag(e_o),
    .f_flag(f_o), .hit(hit)
  );

  assign dec_unused = dec[2];
  assign t0_o = dec[0];
  assign t1_o = dec[1];
  assign t2_o = dec[3];
endmodule

// File: rtl/asm_count_ctl_chk.sv
module asm_count_ctl_chk #(
  parameter int CNT_W  = 4,
  parameter int TAP_LO = 1,
  parameter int TAP_HI = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] cnt_o,
  input logic             e_o,
  input logic             f_o,
  input logic             t0_o,
  input logic             t1_o,
  input logic             t2_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> t0_o && cnt_o == '0 && !e_o && !f_o);

  a_r8_one_state: assert property (@(posedge clk) disable iff (rst)
    $countones({t0_o, t1_o, t2_o}) == 1);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    t0_o && !start |=> t0_o && $stable(cnt_o) && $stable(e_o) && $stable(f_o));

  a_r3_start_clear: assert property (@(posedge clk) disable iff (rst)
    t0_o && start |=> t1_o && cnt_o == '0 && !f_o && $stable(e_o));

  a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
    t1_o |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  a_r5_e_follow: assert property (@(posedge clk) disable iff (rst)
    t1_o |=> e_o == $past(cnt_o[TAP_LO]));

  a_r6_exit: assert property (@(posedge clk) disable iff (rst)
    t1_o && cnt_o[TAP_LO] && cnt_o[TAP_HI] |=> t2_o);

  a_r6_stay: assert property (@(posedge clk) disable iff (rst)
    t1_o && !(cnt_o[TAP_LO] && cnt_o[TAP_HI]) |=> t1_o);

  a_r7_done: assert property (@(posedge clk) disable iff (rst)
    t2_o |=> t0_o && f_o && $stable(cnt_o) && $stable(e_o));

  a_r9_f_hold: assert property (@(posedge clk) disable iff (rst)
    t1_o |=> $stable(f_o));
endmodule

bind asm_count_ctl asm_count_ctl_chk #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cnt_o(cnt_o), .e_o(e_o), .f_o(f_o),
  .t0_o(t0_o), .t1_o(t1_o), .t2_o(t2_o)
);

// File: tb/sim_asm_count_ctl.sv
`timescale 1ns/1ps
module sim_asm_count_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] cnt_o;
  logic       e_o, f_o, t0_o, t1_o, t2_o;

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  // reference model: state code (idle 00, run 01, done 11), count, flags
  logic [1:0] m_st = 2'b00;
  logic [3:0] m_a  = 4'd0;
  logic       m_e  = 1'b0;
  logic       m_f  = 1'b0;

  always #2 clk = ~clk;

  asm_count_ctl u0 (
    .clk(clk), .rst(rst), .start(start), .cnt_o(cnt_o), .e_o(e_o),
    .f_o(f_o), .t0_o(t0_o), .t1_o(t1_o), .t2_o(t2_o)
  );

  function automatic logic [1:0] exp_next_st(logic [1:0] st, logic s, logic [3:0] a);
    case (st)
      2'b00:   return s ? 2'b01 : 2'b00;
      2'b01:   return (a[1] && a[2]) ? 2'b11 : 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [2:0] exp_lines(logic [1:0] st);
    return {st == 2'b11, st == 2'b01, st == 2'b00};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge: apply inputs, advance model over one posedge, compare
  task automatic cycle(input logic s, input logic r);
    logic [1:0] pst;
    logic [3:0] pa;
    start = s;
    rst   = r;
    pst = m_st;
    pa  = m_a;
    if (r) begin
      m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
    end else begin
      m_st = exp_next_st(pst, s, pa);
      case (pst)
        2'b00: if (s) begin m_a = 4'd0; m_f = 1'b0; end
        2'b01: begin m_a = pa + 4'd1; m_e = pa[1]; end
        2'b11: m_f = 1'b1;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      check("R1", "state", {t2_o, t1_o, t0_o}, 3'b001);
      check("R1", "cnt", cnt_o, 0);
      check("R1", "e/f", {e_o, f_o}, 2'b00);
    end else begin
      case (pst)
        2'b00: if (s) begin
          check("R3", "state", {t2_o, t1_o, t0_o}, exp_lines(m_st));
          check("R3", "cnt", cnt_o, m_a);
          check("R3", "f", f_o, m_f);
          check("R9", "e", e_o, m_e);
        end else begin
          check("R2", "state", {t2_o, t1_o, t0_o}, exp_lines(m_st));
          check("R2", "cnt/e/f", {cnt_o, e_o, f_o}, {m_a, m_e, m_f});
        end
        2'b01: begin
          check("R4", "cnt", cnt_o, m_a);
          check("R5", "e", e_o, m_e);
          check("R6", "state", {t2_o, t1_o, t0_o}, exp_lines(m_st));
          check("R9", "f", f_o, m_f);
        end
        default: begin
          check("R7", "state", {t2_o, t1_o, t0_o}, exp_lines(m_st));
          check("R7", "f/cnt", {f_o, cnt_o}, {m_f, m_a});
          check("R9", "e", e_o, m_e);
        end
      endcase
      check("R8", "one-hot", $countones({t0_o, t1_o, t2_o}), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
    // single start pulse, full run: counts 0..6, done with 7
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0);
    // start held high: back-to-back runs, ignored in run (R4)
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0);
    // reset in the middle of a run
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);
    // random stimulus
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 4) == 0, ($urandom % 200) == 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule